// File: doc/BRIEF.md
# Per-Rank ODT Mask Driver

This block drives the on-die termination (ODT) pins of a DRAM channel with up to four rank positions: two modules, each with two ranks. Two mask registers hold one field per rank position, one register for writes and one for reads. When the command scheduler issues an access, the block looks up the field of the targeted rank in the table for that command type. It then drives the ODT pins with that pattern for a programmable window, which opens after a programmable delay.

The memory controller loads the two mask registers and a timing register through a simple write-only configuration port. Each access is presented as a single-cycle command strobe, together with a read/write flag and a rank index. Commands are always accepted. There is no back-pressure on either input, because a later command simply replaces the earlier one. For a read, the pin of the rank being read is always forced low, so a rank never terminates its own read data. The pattern and both timing counts are captured when the command is strobed, so a register write that lands during an active window does not disturb that window.

Top module: `odt_mask_driver`

## Requirements
- R1: `odt_o` has one bit per rank position. Bit i belongs to rank position i (0 = module 0 rank 0, 1 = module 0 rank 1, 2 = module 1 rank 0, 3 = module 1 rank 1). `cmd_rank` selects the field at bits [8r+7:8r] of a mask register.
- R2: For a write command to rank r, the window pattern is bits [8r+3:8r] of the write mask. With a write mask of 0x0C0C0303, ranks 0 to 3 give 0x3, 0x3, 0xC and 0xC.
- R3: For a read command to rank r, the window pattern is bits [8r+3:8r] of the read mask with bit r cleared. With a read mask of 0xFFFFFFFF, ranks 0 to 3 give 0xE, 0xD, 0xB and 0x7. With 0x01010202 they give 0x2, 0x0, 0x1 and 0x1.
- R4: A mask register holding all zeros keeps every pin low for commands of its type, while the other command type is unaffected.
- R5: With delay D in timing bits [3:0], the pins take the pattern in the cycle that follows D rising edges after the edge that captured the strobe. D = 0 means the cycle right after the strobe.
- R6: With window L in timing bits [7:4], the pattern stays on the pins for exactly L cycles and then the pins return to zero. L = 0 keeps the pins low.
- R7: A command that arrives while a delay or window is running restarts the timing from that command with the new rank's pattern. The pins are low during the new delay.
- R8: All ODT pins are zero during reset and while no window is active.
- R9: `cfg_addr` 0 loads the write mask, 1 loads the read mask, 2 loads the timing register and 3 changes nothing. Bits [8r+7:8r+4] of a mask field never reach the pins. A configuration write made during a window does not alter that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 write mask, 1 read mask, 2 timing |
| cfg_wdata | input | 32 | Configuration write data |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_rank | input | 2 | Target rank position of the command |
| odt_o | output | 4 | ODT pins, one per rank position |

## Verification
The bench uses the default parameters: four rank positions, 8-bit mask fields and 4-bit delay and window counts. With these values, every rank index, both command types and the full range of delay and window lengths, including zero, can be driven with short directed sequences. The two example mask words are exercised rank by rank. An all-ones read mask shows the self-clear rule on each rank. Commands placed in the middle of delays and windows, together with configuration writes during an active window, cover the restart and capture behaviour.

// File: rtl/odt_pkg.sv
package odt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_ON   = 2'd2
  } odt_phase_e;

  localparam logic [1:0] CFG_WMASK  = 2'd0;
  localparam logic [1:0] CFG_RMASK  = 2'd1;
  localparam logic [1:0] CFG_TIMING = 2'd2;
endpackage

// File: rtl/odt_cfg_regs.sv
module odt_cfg_regs #(
  parameter int NUM_RANKS = 4,
  parameter int FIELD_W   = 8,
  parameter int CNT_W     = 4,
  localparam int MASK_W   = NUM_RANKS * FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [MASK_W-1:0] cfg_wdata,
  output logic [MASK_W-1:0] wmask_q,
  output logic [MASK_W-1:0] rmask_q,
  output logic [CNT_W-1:0]  dly_q,
  output logic [CNT_W-1:0]  win_q
);
  import odt_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wmask_q <= '0;
      rmask_q <= '0;
      dly_q   <= '0;
      win_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_WMASK:  wmask_q <= cfg_wdata;
        CFG_RMASK:  rmask_q <= cfg_wdata;
        CFG_TIMING: begin
          dly_q <= cfg_wdata[CNT_W-1:0];
          win_q <= cfg_wdata[2*CNT_W-1:CNT_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/odt_pattern_sel.sv
module odt_pattern_sel #(
  parameter int NUM_RANKS = 4,
  parameter int FIELD_W   = 8,
  parameter int RANK_W    = $clog2(NUM_RANKS),
  localparam int MASK_W   = NUM_RANKS * FIELD_W
) (
  input  logic [MASK_W-1:0]    wmask,
  input  logic [MASK_W-1:0]    rmask,
  input  logic                 is_write,
  input  logic [RANK_W-1:0]    rank,
  output logic [NUM_RANKS-1:0] pattern
);
  logic [NUM_RANKS-1:0] wr_tab [NUM_RANKS];
  logic [NUM_RANKS-1:0] rd_tab [NUM_RANKS];

  // Each table entry keeps only the low bits of its field; read entries
  // have their own rank's bit removed at build time.
  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_tab
    assign wr_tab[g] = wmask[g*FIELD_W +: NUM_RANKS];
    assign rd_tab[g] = rmask[g*FIELD_W +: NUM_RANKS] & ~(NUM_RANKS'(1) << g);
  end

  always_comb begin
    pattern = is_write ? wr_tab[rank] : rd_tab[rank];
  end
endmodule

// File: rtl/odt_window_timer.sv
module odt_window_timer #(
  parameter int NUM_RANKS = 4,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NUM_RANKS-1:0] pat_in,
  input  logic [CNT_W-1:0]     dly,
  input  logic [CNT_W-1:0]     win,
  output logic [NUM_RANKS-1:0] odt_q
);
  import odt_pkg::*;

  odt_phase_e           phase_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     len_q;
  logic [NUM_RANKS-1:0] pat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      pat_q   <= '0;
      odt_q   <= '0;
    end else if (start) begin
      pat_q <= pat_in;
      len_q <= win;
      if (dly != '0) begin
        phase_q <= PH_WAIT;
        cnt_q   <= dly - CNT_W'(1);
        odt_q   <= '0;
      end else if (win != '0) begin
        phase_q <= PH_ON;
        cnt_q   <= win - CNT_W'(1);
        odt_q   <= pat_in;
      end else begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
        odt_q   <= '0;
      end
    end else begin
      case (phase_q)
        PH_WAIT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (len_q != '0) begin
            phase_q <= PH_ON;
            cnt_q   <= len_q - CNT_W'(1);
            odt_q   <= pat_q;
          end else begin
            phase_q <= PH_IDLE;
          end
        end
        PH_ON: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else begin
            phase_q <= PH_IDLE;
            odt_q   <= '0;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          odt_q   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/odt_mask_driver.sv
module odt_mask_driver #(
  parameter int NUM_RANKS = 4,
  parameter int FIELD_W   = 8,
  parameter int CNT_W     = 4,
  parameter int RANK_W    = $clog2(NUM_RANKS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [1:0]                   cfg_addr,
  input  logic [NUM_RANKS*FIELD_W-1:0] cfg_wdata,
  input  logic                         cmd_valid,
  input  logic                         cmd_write,
  input  logic [RANK_W-1:0]            cmd_rank,
  output logic [NUM_RANKS-1:0]         odt_o
);
  localparam int MASK_W = NUM_RANKS * FIELD_W;

  logic [MASK_W-1:0]    wmask, rmask;
  logic [CNT_W-1:0]     dly, win;
  logic [NUM_RANKS-1:0] sel_pat;

  odt_cfg_regs #(
    .NUM_RANKS(NUM_RANKS), .FIELD_W(FIELD_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wmask_q(wmask), .rmask_q(rmask),
    .dly_q(dly), .win_q(win)
  );

  odt_pattern_sel #(
    .NUM_RANKS(NUM_RANKS), .FIELD_W(FIELD_W), .RANK_W(RANK_W)
  ) u_sel (
    .wmask(wmask), .rmask(rmask), .is_write(cmd_write),
    .rank(cmd_rank), .pattern(sel_pat)
  );

  odt_window_timer #(
    .NUM_RANKS(NUM_RANKS), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cmd_valid), .pat_in(sel_pat),
    .dly(dly), .win(win), .odt_q(odt_o)
  );
endmodule

// File: rtl/odt_mask_driver_chk.sv
module odt_mask_driver_chk #(
  parameter int NUM_RANKS = 4,
  parameter int FIELD_W   = 8,
  parameter int CNT_W     = 4,
  parameter int RANK_W    = $clog2(NUM_RANKS)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cfg_we,
  input logic [1:0]                   cfg_addr,
  input logic [NUM_RANKS*FIELD_W-1:0] cfg_wdata,
  input logic                         cmd_valid,
  input logic                         cmd_write,
  input logic [RANK_W-1:0]            cmd_rank,
  input logic [NUM_RANKS-1:0]         odt_o
);
  localparam int MASK_W = NUM_RANKS * FIELD_W;

  logic [MASK_W-1:0]    sh_wm, sh_rm;
  logic [CNT_W-1:0]     sh_dly, sh_win;
  logic                 last_rd;
  logic [RANK_W-1:0]    last_rank;
  logic [NUM_RANKS-1:0] last_field;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_wm <= '0; sh_rm <= '0; sh_dly <= '0; sh_win <= '0;
      last_rd <= 1'b0; last_rank <= '0; last_field <= '0;
    end else begin
      if (cfg_we && cfg_addr == 2'd0) sh_wm <= cfg_wdata;
      if (cfg_we && cfg_addr == 2'd1) sh_rm <= cfg_wdata;
      if (cfg_we && cfg_addr == 2'd2) begin
        sh_dly <= cfg_wdata[CNT_W-1:0];
        sh_win <= cfg_wdata[2*CNT_W-1:CNT_W];
      end
      if (cmd_valid) begin
        last_rd    <= !cmd_write;
        last_rank  <= cmd_rank;
        last_field <= cmd_write ? sh_wm[cmd_rank*FIELD_W +: NUM_RANKS]
                                : sh_rm[cmd_rank*FIELD_W +: NUM_RANKS];
      end
    end
  end

  // R3: a read never terminates the rank being read
  p_read_self_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (odt_o != '0 && last_rd) |-> odt_o[last_rank] == 1'b0);

  // R2: driven pins are a subset of the selected field
  p_subset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (odt_o != '0) |-> ((odt_o & ~last_field) == '0));

  // R7: pins quiet during the delay of a new command
  p_delay_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && sh_dly != '0) |=> odt_o == '0);

  // R6: a zero window never drives the pins
  p_zero_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && sh_win == '0) |=> odt_o == '0);

  // R8: pins low on the first cycle out of reset
  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> odt_o == '0);
endmodule

bind odt_mask_driver odt_mask_driver_chk #(
  .NUM_RANKS(NUM_RANKS), .FIELD_W(FIELD_W), .CNT_W(CNT_W), .RANK_W(RANK_W)
) chk_i (.*);

// File: tb/odt_mask_driver_tb_top.sv
module odt_mask_driver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [1:0]  cmd_rank = '0;
  logic [3:0]  odt_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  odt_mask_driver dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_rank(cmd_rank), .odt_o(odt_o)
  );

  task automatic chk(input logic [3:0] exp, input string tag);
    vectors++;
    if (odt_o !== exp) begin
      miscompares++;
      $display("FAIL %s: odt_o actual=%h expected=%h", tag, odt_o, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic wr, input logic [1:0] rk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_rank = rk;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_window(input logic [3:0] exp, input int d, input int l,
                            input int first, input string tag);
    for (int j = first; j <= d + l + 2; j++) begin
      chk((j >= d + 1 && j <= d + l) ? exp : 4'h0, tag);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(4'h0, "R8 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(4'h0, "R8 idle after reset");
  endtask

  task automatic t_write_masks;
    logic [3:0] exp [4] = '{4'h3, 4'h3, 4'hC, 4'hC};
    cfg_write(2'd0, 32'h0C0C0303);
    cfg_write(2'd2, 32'h0000_0020);
    for (int r = 0; r < 4; r++) begin
      issue(1'b1, 2'(r));
      run_window(exp[r], 0, 2, 1, "R1 R2 write field per rank");
    end
  endtask

  task automatic t_read_masks;
    logic [3:0] ex1 [4] = '{4'h2, 4'h0, 4'h1, 4'h1};
    logic [3:0] ex2 [4] = '{4'hE, 4'hD, 4'hB, 4'h7};
    cfg_write(2'd1, 32'h01010202);
    for (int r = 0; r < 4; r++) begin
      issue(1'b0, 2'(r));
      run_window(ex1[r], 0, 2, 1, "R3 read field example");
    end
    cfg_write(2'd1, 32'hFFFFFFFF);
    for (int r = 0; r < 4; r++) begin
      issue(1'b0, 2'(r));
      run_window(ex2[r], 0, 2, 1, "R3 read self-clear");
    end
  endtask

  task automatic t_upper_ignored;
    cfg_write(2'd0, 32'hF0F0F0F0);
    for (int r = 0; r < 4; r++) begin
      issue(1'b1, 2'(r));
      run_window(4'h0, 0, 2, 1, "R9 upper field bits ignored");
    end
  endtask

  task automatic t_timing;
    cfg_write(2'd0, 32'h0C0C0303);
    cfg_write(2'd2, 32'h0000_0043);
    issue(1'b1, 2'd2);
    run_window(4'hC, 3, 4, 1, "R5 R6 delay 3 window 4");
    cfg_write(2'd2, 32'h0000_00F0);
    issue(1'b1, 2'd0);
    run_window(4'h3, 0, 15, 1, "R6 window 15");
    cfg_write(2'd2, 32'h0000_000F);
    issue(1'b1, 2'd0);
    run_window(4'h0, 15, 0, 1, "R6 zero window");
    cfg_write(2'd2, 32'h0000_0011);
    issue(1'b0, 2'd3);
    run_window(4'h7, 1, 1, 1, "R5 delay 1 window 1");
  endtask

  task automatic t_zero_mask;
    cfg_write(2'd0, 32'h0);
    cfg_write(2'd1, 32'h0F0F0F0F);
    cfg_write(2'd2, 32'h0000_0030);
    issue(1'b1, 2'd1);
    run_window(4'h0, 0, 3, 1, "R4 zero write mask");
    issue(1'b0, 2'd1);
    run_window(4'hD, 0, 3, 1, "R4 read unaffected");
    cfg_write(2'd1, 32'h0);
    issue(1'b0, 2'd2);
    run_window(4'h0, 0, 3, 1, "R4 zero read mask");
  endtask

  task automatic t_restart;
    cfg_write(2'd0, 32'h0C0C0303);
    cfg_write(2'd2, 32'h0000_0050);
    issue(1'b1, 2'd0);
    chk(4'h3, "R7 first window");
    @(negedge clk);
    issue(1'b1, 2'd2);
    run_window(4'hC, 0, 5, 1, "R7 restart in window");
    cfg_write(2'd2, 32'h0000_0032);
    issue(1'b1, 2'd0);
    chk(4'h0, "R7 first delay");
    @(negedge clk);
    chk(4'h0, "R7 first delay");
    issue(1'b1, 2'd3);
    run_window(4'hC, 2, 3, 1, "R7 restart in delay");
  endtask

  task automatic t_cfg_stable;
    cfg_write(2'd2, 32'h0000_0040);
    issue(1'b1, 2'd0);
    chk(4'h3, "R9 window start");
    cfg_write(2'd0, 32'h0);
    cfg_write(2'd2, 32'h0000_0010);
    run_window(4'h3, 0, 4, 3, "R9 window keeps captured pattern");
    cfg_write(2'd0, 32'h0C0C0303);
    cfg_write(2'd2, 32'h0000_0021);
    cfg_write(2'd3, 32'hFFFFFFFF);
    issue(1'b1, 2'd2);
    run_window(4'hC, 1, 2, 1, "R9 address 3 ignored");
  endtask

  initial begin
    t_reset;
    t_write_masks;
    t_read_masks;
    t_upper_ignored;
    t_timing;
    t_zero_mask;
    t_restart;
    t_cfg_stable;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule